// File: doc/BRIEF.md
# Frame-Sync Serial Transmitter

This block shifts parallel words out on a single data pin, most significant bit first, while producing or accepting a frame sync that marks where each word begins. Software fills a one-word holding buffer through a small register port and sets the framing options in a control word. A ready flag shows when the holding buffer may be written again. The options cover the sync source (generated here or taken from a pin), its polarity, whether it leads the first bit or marks the whole word, whether every word needs a sync, and whether syncs follow the data or run at a fixed rate.

The bit clock is either divided down from the system clock or taken from an input pin. The divided clock runs only while the port is enabled. A new divider value written while the port is enabled waits for the next frame boundary. An incoming sync is ignored for a short window after each enable. Each re-enable makes the port wait again for a sync before it sends the first word.

Top module: `fstx_top`

## Requirements
- R1: In late mode (control bit 4 = 1) the frame sync goes active on the same serial clock as the first data bit and stays active for every bit of that word. This holds for active-high and active-low (control bit 3 = 1) polarity.
- R2: In early mode (control bit 4 = 0) the frame sync is active for exactly one serial clock, directly before the first data bit. This holds for an externally supplied sync, and when the holding buffer is written while the last bit of the previous word is on the pin (the sync then comes one clock after that last bit).
- R3: With a data-dependent internal sync (control bit 6 = 0) a sync is produced only when the holding buffer holds a word. With a data-independent sync (bit 6 = 1) a frame starts every word-length serial clocks even if the buffer is empty.
- R4: Words of 3 to 16 bits (control bits 10:7 hold length minus one) leave MSB first, one bit per serial clock. tx_ready falls on a write to the data address (2) and rises when the word moves into the shift register.
- R5: With an external sync (control bit 2 = 0) and unframed operation (bit 5 = 0), no data leaves after an enable until a sync is accepted. Later words then follow without a sync until the port is disabled, and the next enable re-arms the wait.
- R6: An external sync seen on any of the first 6 serial clocks after enable is ignored. A sync on the 7th serial clock is accepted.
- R7: With the internal clock (control bit 1 = 1) sclk_o has a period of 2*(div+1) system clocks (div written at address 1, 0 after reset). It stays low while the port is disabled (control bit 0 = 0). Clearing bit 1 in the cycle right after a disable keeps it low.
- R8: A divider write while the port is enabled leaves the serial clock period unchanged until the next frame sync, and applies from that sync on.
- R9: With control bit 1 = 0 the bits advance on rising edges of sclk_i and sclk_o stays low.
- R10: After reset tx_ready is 1, sclk_o, sd_o and fs_o are 0, and the control word (address 0) is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | 0 control, 1 divider, 2 transmit data |
| cfg_wdata | input | 16 | Register write data |
| tx_ready | output | 1 | Holding buffer is empty |
| sclk_i | input | 1 | External serial clock |
| sclk_o | output | 1 | Generated serial clock |
| fs_i | input | 1 | External frame sync |
| fs_o | output | 1 | Generated frame sync |
| sd_o | output | 1 | Serial data |

## Verification
The hardest state to reach is a buffer write that lands while the last bit of a word is on the pin in early mode. The bench slows the serial clock, records every serial clock period, and issues the write right after it sees the last bit begin. It then checks that the next sync sits exactly one period before the new word. The guard window is probed by pulsing the external sync at the last ignored period and at the first accepted one. The deferred divider change is seen in the recorded edge timestamps on either side of the next sync.

// File: rtl/fstx_pkg.sv
package fstx_pkg;

    localparam int WORD_MAX = 16;

    typedef enum logic [1:0] {
        A_CTL  = 2'd0,
        A_DIV  = 2'd1,
        A_DATA = 2'd2
    } addr_e;

    typedef struct packed {
        logic [3:0] wlen_m1;
        logic       indep;
        logic       framed;
        logic       late;
        logic       act_low;
        logic       int_fs;
        logic       int_clk;
        logic       en;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    function automatic logic [4:0] eff_len(input logic [3:0] m1);
        return (m1 < 4'd2) ? 5'd3 : ({1'b0, m1} + 5'd1);
    endfunction

endpackage

// File: rtl/fstx_regs.sv
module fstx_regs
    import fstx_pkg::*;
#(
    parameter int DIVW = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [1:0]          cfg_addr,
    input  logic [15:0]         cfg_wdata,
    input  logic                take,
    output ctl_t                ctl,
    output logic [DIVW-1:0]     div_reg,
    output logic                buf_full,
    output logic [WORD_MAX-1:0] buf_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl      <= '0;
            div_reg  <= '0;
            buf_full <= 1'b0;
            buf_data <= '0;
        end else begin
            if (take) buf_full <= 1'b0;
            if (cfg_we) begin
                case (addr_e'(cfg_addr))
                    A_CTL:   ctl <= ctl_t'(cfg_wdata[CTL_W-1:0]);
                    A_DIV:   div_reg <= cfg_wdata[DIVW-1:0];
                    A_DATA: begin
                        buf_data <= cfg_wdata[WORD_MAX-1:0];
                        buf_full <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/fstx_clkgen.sv
module fstx_clkgen #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            int_clk,
    input  logic [DIVW-1:0] div_reg,
    input  logic            frame_evt,
    input  logic            sclk_i,
    output logic            tick,
    output logic            sclk_o
);

    logic [DIVW-1:0] div_act;
    logic [DIVW-1:0] cnt;
    logic            sclk_q;
    logic            ext_q;
    logic            run;

    assign run = en && int_clk;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_act <= '0;
            cnt     <= '0;
            sclk_q  <= 1'b0;
            ext_q   <= 1'b0;
        end else begin
            ext_q <= sclk_i;
            if (!en || frame_evt) div_act <= div_reg;
            if (!run) begin
                cnt    <= '0;
                sclk_q <= 1'b0;
            end else if (cnt >= div_act) begin
                cnt    <= '0;
                sclk_q <= !sclk_q;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign tick   = en && (int_clk ? (run && (cnt >= div_act) && !sclk_q)
                                   : (sclk_i && !ext_q));
    assign sclk_o = sclk_q;

    // R8: the active divider only moves on a frame sync or while disabled
    a_r8_div_hold: assert property (@(posedge clk) disable iff (rst)
        (en && !frame_evt) |=> $stable(div_act));

endmodule

// File: rtl/fstx_engine.sv
module fstx_engine
    import fstx_pkg::*;
#(
    parameter int GUARD = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  ctl_t                ctl,
    input  logic                buf_full,
    input  logic [WORD_MAX-1:0] buf_data,
    input  logic                fs_i,
    output logic                take,
    output logic                frame_evt,
    output logic                sd_o,
    output logic                fs_o
);

    localparam int GW = $clog2(GUARD + 1);

    logic [WORD_MAX-1:0] sr;
    logic [4:0]          left;
    logic                pend, word_sync, locked, sd_q, fs_q;
    logic [GW-1:0]       guard;

    logic [4:0]          wl;
    logic                guard_ok, ext_act, have, synced, trig;
    logic                start, announce, fs_now;
    logic [WORD_MAX-1:0] wdata, aligned;

    always_comb begin
        wl       = eff_len(ctl.wlen_m1);
        guard_ok = (guard == GW'(GUARD));
        ext_act  = (fs_i ^ ctl.act_low) && guard_ok;
        have     = ctl.indep || buf_full;
        synced   = !locked;
        wdata    = buf_full ? buf_data : '0;
        aligned  = wdata << (5'(WORD_MAX) - wl);
        trig     = ctl.int_fs ? have : ext_act;
        start    = 1'b0;
        announce = 1'b0;
        if (locked) begin
            start = (left == 5'd0) && have;
        end else if (ctl.late) begin
            start = (left == 5'd0) && trig;
        end else begin
            announce = (left <= 5'd1) && !pend && trig;
            start    = pend;
        end
        fs_now = ctl.int_fs && (ctl.late ? ((start && synced) || (left != 5'd0 && word_sync))
                                         : announce);
    end

    assign take      = tick && ctl.en && start && buf_full;
    assign frame_evt = tick && ctl.en && synced && (ctl.late ? start : announce);

    always_ff @(posedge clk) begin
        if (rst || !ctl.en) begin
            sr        <= '0;
            left      <= '0;
            pend      <= 1'b0;
            word_sync <= 1'b0;
            locked    <= 1'b0;
            sd_q      <= 1'b0;
            fs_q      <= 1'b0;
            guard     <= '0;
        end else if (tick) begin
            if (!guard_ok) guard <= guard + 1'b1;
            pend <= announce;
            fs_q <= fs_now;
            if (start) begin
                sd_q      <= aligned[WORD_MAX-1];
                sr        <= aligned << 1;
                left      <= wl - 5'd1;
                word_sync <= synced;
                if (!ctl.framed && synced) locked <= 1'b1;
            end else if (left != 5'd0) begin
                sd_q <= sr[WORD_MAX-1];
                sr   <= sr << 1;
                left <= left - 5'd1;
            end else begin
                sd_q <= 1'b0;
            end
        end
    end

    assign sd_o = sd_q;
    assign fs_o = fs_q ^ ctl.act_low;

    // R2: a word announced by an early sync starts only after the previous one drained
    a_r2_no_overlap: assert property (@(posedge clk) disable iff (rst)
        (tick && ctl.en && pend) |-> (left == 5'd0));

    // R6: no external sync is taken inside the guard window
    a_r6_guard: assert property (@(posedge clk) disable iff (rst)
        (tick && ctl.en && !ctl.int_fs && !locked && !pend && guard != GW'(GUARD))
            |-> !(start || announce));

    // R1: a late internal sync covers the remaining bits of its word
    a_r1_late_hold: assert property (@(posedge clk) disable iff (rst)
        (tick && ctl.en && ctl.int_fs && ctl.late && word_sync && left > 5'd1)
            |=> (fs_q || !ctl.en));

endmodule

// File: rtl/fstx_top.sv
module fstx_top
    import fstx_pkg::*;
#(
    parameter int DIVW  = 8,
    parameter int GUARD = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_addr,
    input  logic [15:0] cfg_wdata,
    output logic        tx_ready,
    input  logic        sclk_i,
    output logic        sclk_o,
    input  logic        fs_i,
    output logic        fs_o,
    output logic        sd_o
);

    ctl_t                ctl;
    logic [DIVW-1:0]     div_reg;
    logic                buf_full;
    logic [WORD_MAX-1:0] buf_data;
    logic                take, frame_evt, tick;

    fstx_regs #(.DIVW(DIVW)) regs_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .take(take), .ctl(ctl), .div_reg(div_reg),
        .buf_full(buf_full), .buf_data(buf_data)
    );

    fstx_clkgen #(.DIVW(DIVW)) clkgen_i (
        .clk(clk), .rst(rst), .en(ctl.en), .int_clk(ctl.int_clk),
        .div_reg(div_reg), .frame_evt(frame_evt), .sclk_i(sclk_i),
        .tick(tick), .sclk_o(sclk_o)
    );

    fstx_engine #(.GUARD(GUARD)) engine_i (
        .clk(clk), .rst(rst), .tick(tick), .ctl(ctl), .buf_full(buf_full),
        .buf_data(buf_data), .fs_i(fs_i), .take(take), .frame_evt(frame_evt),
        .sd_o(sd_o), .fs_o(fs_o)
    );

    assign tx_ready = !buf_full;

    // R7: a disabled port drives no serial clock edges
    a_r7_sclk_gated: assert property (@(posedge clk) disable iff (rst)
        !ctl.en |=> !sclk_o);

    // R4: moving a word into the shift register frees the holding buffer
    a_r4_ready_rise: assert property (@(posedge clk) disable iff (rst)
        (take && !(cfg_we && cfg_addr == A_DATA)) |=> tx_ready);

endmodule

// File: tb/fstx_top_tb_top.sv
module fstx_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NREC = 256;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        tx_ready, sclk_o, fs_o, sd_o;
    logic        sclk_i = 1'b0;
    logic        fs_i = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    fstx_top dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .tx_ready(tx_ready), .sclk_i(sclk_i),
        .sclk_o(sclk_o), .fs_i(fs_i), .fs_o(fs_o), .sd_o(sd_o)
    );

    always #(CLK_PERIOD / 2) clk = !clk;

    // per-serial-clock recorder, sampled on falling system clock edges
    logic fsv [NREC];
    logic sdv [NREC];
    int   tcyc [NREC];
    int   ntick = 0;
    int   cyc = 0;
    int   sclk_hi = 0;
    logic low_b = 1'b0;
    logic rec_ext = 1'b0;
    logic ext_run = 1'b0;
    logic sclk_prev = 1'b0;
    logic sclki_prev = 1'b0;
    int   ext_cnt = 0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (sclk_o) sclk_hi = sclk_hi + 1;
        if (ntick < NREC && ((!rec_ext && sclk_o && !sclk_prev) ||
                             (rec_ext && !sclk_i && sclki_prev))) begin
            fsv[ntick]  = fs_o ^ low_b;
            sdv[ntick]  = sd_o;
            tcyc[ntick] = cyc;
            ntick = ntick + 1;
        end
        sclk_prev  = sclk_o;
        sclki_prev = sclk_i;
    end

    always @(negedge clk) begin
        #2;
        if (ext_run) begin
            ext_cnt = ext_cnt + 1;
            if (ext_cnt == 5) begin
                ext_cnt = 0;
                sclk_i = !sclk_i;
            end
        end else begin
            ext_cnt = 0;
            sclk_i = 1'b0;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk  = n_chk + 1;
        n_fail = n_fail + 1;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    task automatic chk(input int act, input int exp, input string tag);
        n_chk = n_chk + 1;
        if (act != exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [15:0] d);
        cfg_addr  = a;
        cfg_wdata = d;
        cfg_we    = 1'b1;
        @(negedge clk);
        #1;
        cfg_we = 1'b0;
    endtask

    function automatic logic [15:0] ctl_word(input logic en, input logic iclk,
            input logic ifs, input logic low, input logic late, input logic framed,
            input logic indep, input int wl);
        logic [3:0] m1;
        m1 = 4'(wl - 1);
        return {5'b0, m1, indep, framed, late, low, ifs, iclk, en};
    endfunction

    task automatic wait_tick(input int k);
        while (ntick < k) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic clear_rec();
        ntick   = 0;
        sclk_hi = 0;
    endtask

    task automatic stop_port();
        cfg_write(2'd0, 16'h0000);
        idle(4);
    endtask

    function automatic int find_fs(input int from);
        if (from < 0) return -1;
        for (int i = from; i < NREC; i++)
            if (i < ntick && fsv[i]) return i;
        return -1;
    endfunction

    function automatic int get_word(input int idx, input int wl);
        int v;
        v = 0;
        if (idx < 0 || idx + wl > ntick) return -1;
        for (int i = 0; i < wl; i++) v = (v << 1) | int'(sdv[idx + i]);
        return v;
    endfunction

    function automatic int count_fs(input int a, input int b);
        int c;
        c = 0;
        for (int i = a; i <= b; i++) if (i < ntick && fsv[i]) c++;
        return c;
    endfunction

    function automatic int count_sd(input int a, input int b);
        int c;
        c = 0;
        for (int i = a; i <= b; i++) if (i < ntick && sdv[i]) c++;
        return c;
    endfunction

    initial begin
        int f;
        int g;
        int w;
        idle(3);
        rst = 1'b0;
        idle(2);

        // R10: reset state
        chk(int'(tx_ready), 1, "R10 ready after reset");
        chk(int'(sclk_o), 0, "R10 sclk after reset");
        chk(int'(sd_o), 0, "R10 data after reset");
        chk(int'(fs_o), 0, "R10 sync after reset");

        // R1 / R2: polarity x timing, internal data-dependent sync
        for (int low = 0; low < 2; low++) begin
            for (int late = 0; late < 2; late++) begin
                w = 8'hA6 + low * 16 + late * 5;
                clear_rec();
                low_b = 1'(low);
                cfg_write(2'd2, 16'(w));
                chk(int'(tx_ready), 0, "R4 ready falls on write");
                cfg_write(2'd0, ctl_word(1, 1, 1, 1'(low), 1'(late), 1, 0, 8));
                wait_tick(30);
                f = find_fs(0);
                if (late == 1) begin
                    chk(get_word(f, 8), w, "R1 data starts with late sync");
                    chk(count_fs(0, 29), 8, "R1 late sync spans word / R3 one frame");
                end else begin
                    chk(get_word(f + 1, 8), w, "R2 data one clock after early sync");
                    chk(count_fs(0, 29), 1, "R2 single early pulse / R3 one frame");
                end
                chk(int'(tx_ready), 1, "R4 ready after transfer");
                stop_port();
                low_b = 1'b0;
            end
        end

        // R4: word length sweep, MSB first
        for (int wl = 3; wl <= 16; wl++) begin
            w = (16'h9D6B & ((1 << wl) - 1)) | (1 << (wl - 1));
            clear_rec();
            cfg_write(2'd2, 16'(w));
            cfg_write(2'd0, ctl_word(1, 1, 1, 0, 1, 1, 0, wl));
            wait_tick(24);
            f = find_fs(0);
            chk(get_word(f, wl), w, "R4 word content for length");
            chk(count_fs(0, 23), wl, "R4 sync length equals word length");
            stop_port();
        end

        // R3: data-independent early sync runs every word length
        clear_rec();
        cfg_write(2'd0, ctl_word(1, 1, 1, 0, 0, 1, 1, 8));
        wait_tick(30);
        f = find_fs(0);
        chk(find_fs(f + 1), f + 8, "R3 second independent sync");
        chk(find_fs(f + 9), f + 16, "R3 third independent sync");
        stop_port();

        // R2 / R7: buffer written during the last bit, slow clock
        cfg_write(2'd1, 16'd3);
        clear_rec();
        cfg_write(2'd2, 16'h00C3);
        cfg_write(2'd0, ctl_word(1, 1, 1, 0, 0, 1, 0, 8));
        wait_tick(3);
        f = find_fs(0);
        chk(tcyc[2] - tcyc[1], 8, "R7 period with div 3");
        wait_tick(f + 9);
        cfg_write(2'd2, 16'h005A);
        wait_tick(f + 26);
        g = find_fs(f + 1);
        chk(g, f + 9, "R2 sync after late load position");
        chk(get_word(g + 1, 8), 16'h5A, "R2 data after late load");
        chk(count_fs(0, g + 15), 2, "R2 no extra sync");
        stop_port();

        // R8 / R7: divider change waits for the next sync
        cfg_write(2'd1, 16'd0);
        clear_rec();
        cfg_write(2'd0, ctl_word(1, 1, 1, 0, 0, 1, 1, 8));
        wait_tick(3);
        f = find_fs(0);
        chk(tcyc[f + 2] - tcyc[f + 1], 2, "R7 period with div 0");
        wait_tick(f + 2);
        cfg_write(2'd1, 16'd3);
        wait_tick(f + 11);
        chk(tcyc[f + 5] - tcyc[f + 4], 2, "R8 period unchanged before sync");
        chk(int'(fsv[f + 8]), 1, "R8 next sync position");
        chk(tcyc[f + 9] - tcyc[f + 8], 8, "R8 period applied after sync");
        stop_port();
        cfg_write(2'd1, 16'd0);
        idle(2);

        // R7: clock gating and clearing internal clock right after disable
        clear_rec();
        cfg_write(2'd0, ctl_word(0, 1, 1, 0, 1, 1, 0, 8));
        idle(40);
        chk(sclk_hi, 0, "R7 no clock while disabled");
        cfg_write(2'd0, ctl_word(1, 1, 1, 0, 1, 1, 1, 8));
        idle(20);
        chk(int'(sclk_hi > 0), 1, "R7 clock runs when enabled");
        cfg_addr  = 2'd0;
        cfg_wdata = ctl_word(0, 1, 1, 0, 1, 1, 1, 8);
        cfg_we    = 1'b1;
        @(negedge clk);
        #1;
        cfg_wdata = 16'h0000;
        @(negedge clk);
        #1;
        cfg_we = 1'b0;
        idle(1);
        sclk_hi = 0;
        idle(40);
        chk(sclk_hi, 0, "R7 clock held low after disable then clear");

        // R6: guard window, external late framed sync
        for (int k = 3; k <= 6; k += 3) begin
            clear_rec();
            cfg_write(2'd2, 16'h00A5);
            cfg_write(2'd0, ctl_word(1, 1, 0, 0, 1, 1, 0, 8));
            wait_tick(k);
            fs_i = 1'b1;
            wait_tick(k + 1);
            fs_i = 1'b0;
            if (k == 3) begin
                wait_tick(10);
                chk(count_sd(0, 9), 0, "R6 sync inside guard ignored");
                fs_i = 1'b1;
                wait_tick(11);
                fs_i = 1'b0;
                wait_tick(20);
                chk(get_word(10, 8), 16'hA5, "R6 sync after guard accepted");
            end else begin
                wait_tick(16);
                chk(get_word(6, 8), 16'hA5, "R6 sync on seventh clock accepted");
            end
            stop_port();
        end
        clear_rec();
        cfg_write(2'd2, 16'h00B1);
        cfg_write(2'd0, ctl_word(1, 1, 0, 0, 1, 1, 0, 8));
        wait_tick(5);
        fs_i = 1'b1;
        wait_tick(6);
        fs_i = 1'b0;
        wait_tick(16);
        chk(count_sd(0, 15), 0, "R6 sync on sixth clock ignored");
        stop_port();

        // R2: external early sync, active low
        clear_rec();
        fs_i = 1'b1;
        cfg_write(2'd2, 16'h0096);
        cfg_write(2'd0, ctl_word(1, 1, 0, 1, 0, 1, 0, 8));
        wait_tick(8);
        fs_i = 1'b0;
        wait_tick(9);
        fs_i = 1'b1;
        wait_tick(20);
        chk(get_word(9, 8), 16'h96, "R2 external early sync leads data");
        chk(int'(fs_o), 1, "R2 generated sync idle when external");
        stop_port();
        fs_i = 1'b0;

        // R5: unframed external sync, re-armed on every enable
        clear_rec();
        cfg_write(2'd2, 16'h00E1);
        cfg_write(2'd0, ctl_word(1, 1, 0, 0, 1, 0, 0, 8));
        wait_tick(8);
        fs_i = 1'b1;
        wait_tick(9);
        fs_i = 1'b0;
        wait_tick(10);
        cfg_write(2'd2, 16'h0037);
        wait_tick(26);
        chk(get_word(8, 8), 16'hE1, "R5 first word after sync");
        chk(get_word(16, 8), 16'h37, "R5 next word without sync");
        cfg_write(2'd0, ctl_word(0, 1, 0, 0, 1, 0, 0, 8));
        idle(4);
        clear_rec();
        cfg_write(2'd2, 16'h00CC);
        cfg_write(2'd0, ctl_word(1, 1, 0, 0, 1, 0, 0, 8));
        wait_tick(20);
        chk(count_sd(0, 19), 0, "R5 waits for sync after re-enable");
        chk(int'(tx_ready), 0, "R5 word held while waiting");
        fs_i = 1'b1;
        wait_tick(21);
        fs_i = 1'b0;
        wait_tick(30);
        chk(get_word(20, 8), 16'hCC, "R5 word after re-armed sync");
        stop_port();

        // R9: external serial clock
        clear_rec();
        rec_ext = 1'b1;
        ext_run = 1'b1;
        cfg_write(2'd2, 16'h0071);
        cfg_write(2'd0, ctl_word(1, 0, 1, 0, 1, 1, 0, 8));
        wait_tick(12);
        f = find_fs(0);
        chk(get_word(f, 8), 16'h71, "R9 data on external clock");
        chk(count_fs(0, 11), 8, "R9 late sync on external clock");
        chk(sclk_hi, 0, "R9 sclk_o low with external clock");
        stop_port();
        ext_run = 1'b0;
        rec_ext = 1'b0;
        idle(4);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule